// File: doc/BRIEF.md
# Configuration Port Synchronization Model

A cycle-level behavioural model of a word-wide internal configuration port. A sequencer drives it with an active-low select, a read/write select and a write data word, and the model answers with a 4-bit status nibble. The nibble shows whether the port is locked to a configuration session and whether an error has been latched. No frames are programmed and no readback data is returned. The model exists so that sequencers, status monitors and abort generators can be tested against realistic status behaviour.

The port stays deaf until a sync word arrives. After sync it recognises a small set of command words, which are all parameters: leave-session, clear-checksum, checksum compare and identity compare. The two compares take the next written word as their argument. While synchronised, the port keeps a running checksum, `cks = rotl1(cks) ^ word`. The checksum takes in every synchronised word except the clear-checksum command, the leave-session command, the checksum-compare command and its argument, and a failing identity argument. Toggling the read/write select between two selected cycles starts a fixed abort instead of a transfer.

Top module: `cfgport_model`

## Requirements
- R1: After reset the status nibble reads 4'b1000: error flag released (bit 3 = 1), not synchronised (bit 2 = 0), abort idle (bit 1 = 0). Bit 0 is always 0.
- R2: While not synchronised, every written word is ignored, and the status does not change. This covers pad words 0xFFFFFFFF, width-detect words 0x000000BB and 0x11220044, NOP 0x20000000 and all command words. The one exception is the sync word 0xAA995566, which sets bit 2 on the next clock.
- R3: The leave-session word (default 0x3000800D), written while synchronised, clears bit 2 on the next clock. Command words after it are ignored until the next sync word.
- R4: The clear-checksum word (default 0x30008007), written while synchronised, sets bit 3 to 1 and resets the running checksum to 0.
- R5: The checksum-compare word (default 0x30000001) makes the next written word an argument. If the argument equals the running checksum, the status is unchanged.
- R6: A checksum-compare argument that differs from the running checksum clears bit 3 and bit 2 on the next clock.
- R7: The identity-compare word (default 0x30018001) makes the next written word an argument. If it equals DEV_ID (default 0x0AB12345), the status is unchanged and both words enter the checksum. If it differs, bit 3 and bit 2 are cleared.
- R8: A word is written only in a cycle with select low and read/write select 0. With select high, or with read/write select 1, the word has no effect.
- R9: If select is low in two consecutive cycles and the read/write select differs between them, the second cycle starts an abort and writes nothing. Bit 1 is then 1 for three cycles, during which all words are ignored. The abort ends four clocks after the trigger, with bit 2 at 0.
- R10: Status bit 2 carries the synchronised flag (active high) and bit 3 the error flag (active low, 0 = error).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| rd_wr | input | 1 | Read/write select, 0 = write |
| wdata | input | DATA_W | Write data word |
| status_o | output | 4 | {error_n, synced, abort_busy, 0} |

## Verification
An abort trigger and a command write can land in the same cycle. The trigger cycle has select low and the read/write select back at 0, so it looks like an ordinary write. The bench provokes this with a selected read cycle followed by a selected cycle carrying the leave-session word while the port is synchronised. A correct port keeps the synchronised bit at 1 through the three busy cycles and drops it only when the abort finishes; a port that let the word through would drop it one clock after the trigger.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
   typedef enum logic [1:0] {
      ST_CMD     = 2'd0,
      ST_CRC_ARG = 2'd1,
      ST_ID_ARG  = 2'd2
   } dec_st_e;
endpackage

// File: rtl/cfgport_abort.sv
module cfgport_abort #(
   parameter int ABORT_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_n,
   input  logic rd_wr,
   output logic trig_o,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = $clog2(ABORT_LEN + 1);

   logic          sel_q, rd_q;
   logic [CW-1:0] cnt;

   assign busy_o = (cnt != '0);
   assign done_o = (cnt == CW'(1));
   assign trig_o = !busy_o && !sel_n && !sel_q && (rd_wr != rd_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b1;
         rd_q  <= 1'b0;
         cnt   <= '0;
      end else begin
         sel_q <= sel_n;
         rd_q  <= rd_wr;
         if (trig_o)
            cnt <= CW'(ABORT_LEN - 1);
         else if (busy_o)
            cnt <= cnt - CW'(1);
      end
   end

   // R9
   abort_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |=> busy_o);
endmodule

// File: rtl/cfgport_cksum.sv
module cfgport_cksum #(
   parameter int DATA_W = 32,
   parameter bit ROTATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              acc,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] cks_o
);
   logic [DATA_W-1:0] nxt;

   generate
      if (ROTATE) begin : g_rot
         assign nxt = {cks_o[DATA_W-2:0], cks_o[DATA_W-1]} ^ word;
      end else begin : g_xor
         assign nxt = cks_o ^ word;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cks_o <= '0;
      else if (clr)
         cks_o <= '0;
      else if (acc)
         cks_o <= nxt;
   end
endmodule

// File: rtl/cfgport_decoder.sv
module cfgport_decoder
   import cfgport_pkg::*;
#(
   parameter int              DATA_W = 32,
   parameter logic [DATA_W-1:0] SYNC_W = 32'hAA99_5566,
   parameter logic [DATA_W-1:0] DESYNC_W = 32'h3000_800D,
   parameter logic [DATA_W-1:0] RCRC_W = 32'h3000_8007,
   parameter logic [DATA_W-1:0] CRCCHK_W = 32'h3000_0001,
   parameter logic [DATA_W-1:0] IDCHK_W = 32'h3001_8001,
   parameter logic [DATA_W-1:0] DEV_ID = 32'h0AB1_2345
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] word,
   input  logic [DATA_W-1:0] cks,
   input  logic              abort_start,
   input  logic              abort_done,
   output logic              sync_o,
   output logic              err_n_o,
   output logic              cks_clr,
   output logic              cks_acc
);
   dec_st_e st;
   logic    in_cmd;

   assign in_cmd  = wr && sync_o && (st == ST_CMD);
   assign cks_clr = in_cmd && (word == RCRC_W);
   assign cks_acc = (in_cmd && (word != RCRC_W) && (word != DESYNC_W) &&
                     (word != CRCCHK_W)) ||
                    (wr && sync_o && (st == ST_ID_ARG) && (word == DEV_ID));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_o  <= 1'b0;
         err_n_o <= 1'b1;
         st      <= ST_CMD;
      end else if (abort_done) begin
         sync_o <= 1'b0;
         st     <= ST_CMD;
      end else if (abort_start) begin
         st <= ST_CMD;
      end else if (wr) begin
         if (!sync_o) begin
            if (word == SYNC_W) begin
               sync_o <= 1'b1;
               st     <= ST_CMD;
            end
         end else begin
            unique case (st)
               ST_CRC_ARG: begin
                  st <= ST_CMD;
                  if (word != cks) begin
                     err_n_o <= 1'b0;
                     sync_o  <= 1'b0;
                  end
               end
               ST_ID_ARG: begin
                  st <= ST_CMD;
                  if (word != DEV_ID) begin
                     err_n_o <= 1'b0;
                     sync_o  <= 1'b0;
                  end
               end
               default: begin
                  if (word == DESYNC_W)
                     sync_o <= 1'b0;
                  else if (word == RCRC_W)
                     err_n_o <= 1'b1;
                  else if (word == CRCCHK_W)
                     st <= ST_CRC_ARG;
                  else if (word == IDCHK_W)
                     st <= ST_ID_ARG;
               end
            endcase
         end
      end
   end

   // R2
   idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !sync_o && word != SYNC_W) |=> (!sync_o && $stable(err_n_o)));
   // R3
   desync_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_cmd && word == DESYNC_W) |=> !sync_o);
   // R4
   rcrc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cks_clr |=> err_n_o);
   // R6
   crc_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sync_o && st == ST_CRC_ARG && word != cks) |=> (!err_n_o && !sync_o));
endmodule

// File: rtl/cfgport_model.sv
module cfgport_model #(
   parameter int              DATA_W = 32,
   parameter int              ABORT_LEN = 4,
   parameter bit              CKS_ROTATE = 1'b1,
   parameter logic [DATA_W-1:0] SYNC_W = 32'hAA99_5566,
   parameter logic [DATA_W-1:0] DESYNC_W = 32'h3000_800D,
   parameter logic [DATA_W-1:0] RCRC_W = 32'h3000_8007,
   parameter logic [DATA_W-1:0] CRCCHK_W = 32'h3000_0001,
   parameter logic [DATA_W-1:0] IDCHK_W = 32'h3001_8001,
   parameter logic [DATA_W-1:0] DEV_ID = 32'h0AB1_2345
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              rd_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [3:0]        status_o
);
   logic              trig, busy, done, wr;
   logic              sync, err_n, cks_clr, cks_acc;
   logic [DATA_W-1:0] cks;

   initial begin
      param_len_chk: assert (ABORT_LEN >= 2) else $error("ABORT_LEN must be at least 2");
      param_width_chk: assert (DATA_W >= 8) else $error("DATA_W must be at least 8");
   end

   assign wr = !sel_n && !rd_wr && !trig && !busy;

   cfgport_abort #(.ABORT_LEN(ABORT_LEN)) u_abort (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_wr(rd_wr),
      .trig_o(trig), .busy_o(busy), .done_o(done)
   );

   cfgport_cksum #(.DATA_W(DATA_W), .ROTATE(CKS_ROTATE)) u_cksum (
      .clk(clk), .rst_n(rst_n), .clr(cks_clr), .acc(cks_acc),
      .word(wdata), .cks_o(cks)
   );

   cfgport_decoder #(
      .DATA_W(DATA_W), .SYNC_W(SYNC_W), .DESYNC_W(DESYNC_W), .RCRC_W(RCRC_W),
      .CRCCHK_W(CRCCHK_W), .IDCHK_W(IDCHK_W), .DEV_ID(DEV_ID)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .wr(wr), .word(wdata), .cks(cks),
      .abort_start(trig), .abort_done(done),
      .sync_o(sync), .err_n_o(err_n), .cks_clr(cks_clr), .cks_acc(cks_acc)
   );

   assign status_o = {err_n, sync, busy, 1'b0};

   // R9
   abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !sync);
   // R8
   deselect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n && !busy) |=> ($stable(sync) && $stable(err_n)));
endmodule

// File: tb/cfgport_model_bench.sv
module cfgport_model_bench;
   localparam logic [31:0] SYNC   = 32'hAA99_5566;
   localparam logic [31:0] DESYNC = 32'h3000_800D;
   localparam logic [31:0] RCRC   = 32'h3000_8007;
   localparam logic [31:0] CRCC   = 32'h3000_0001;
   localparam logic [31:0] IDC    = 32'h3001_8001;
   localparam logic [31:0] DEVID  = 32'h0AB1_2345;
   localparam logic [31:0] NOP    = 32'h2000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n = 1'b1;
   logic        rd_wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [3:0]  status_o;

   int total = 0;
   int bad = 0;
   bit drained = 1'b0;

   logic [3:0] exp_q[$];
   string      tag_q[$];

   // reference state, built from the requirements
   logic        m_sync = 1'b0, m_err = 1'b1, m_psel = 1'b1, m_prd = 1'b0;
   int          m_cnt = 0;
   int          m_st = 0;
   logic [31:0] m_cks = '0;

   always #2 clk = ~clk;

   cfgport_model #(
      .SYNC_W(SYNC), .DESYNC_W(DESYNC), .RCRC_W(RCRC), .CRCCHK_W(CRCC),
      .IDCHK_W(IDC), .DEV_ID(DEVID)
   ) u_cfgport_model (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_wr(rd_wr),
      .wdata(wdata), .status_o(status_o)
   );

   task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: status actual=%b expected=%b", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] fold(input logic [31:0] c, input logic [31:0] w);
      return {c[30:0], c[31]} ^ w;
   endfunction

   task automatic step(input logic s, input logic r, input logic [31:0] d, input string tag);
      logic trig, wr;
      @(negedge clk);
      sel_n = s; rd_wr = r; wdata = d;
      trig = (m_cnt == 0) && !s && !m_psel && (r != m_prd);
      wr   = !s && !r && !trig && (m_cnt == 0);
      if (m_cnt != 0) begin
         if (m_cnt == 1) begin m_sync = 1'b0; m_st = 0; end
         m_cnt--;
      end else if (trig) begin
         m_cnt = 3; m_st = 0;
      end else if (wr) begin
         if (!m_sync) begin
            if (d == SYNC) begin m_sync = 1'b1; m_st = 0; end
         end else if (m_st == 1) begin
            m_st = 0;
            if (d != m_cks) begin m_err = 1'b0; m_sync = 1'b0; end
         end else if (m_st == 2) begin
            m_st = 0;
            if (d != DEVID) begin m_err = 1'b0; m_sync = 1'b0; end
            else m_cks = fold(m_cks, d);
         end else begin
            if (d == DESYNC) m_sync = 1'b0;
            else if (d == RCRC) begin m_err = 1'b1; m_cks = '0; end
            else if (d == CRCC) m_st = 1;
            else begin
               if (d == IDC) m_st = 2;
               m_cks = fold(m_cks, d);
            end
         end
      end
      m_psel = s; m_prd = r;
      exp_q.push_back({m_err, m_sync, m_cnt != 0, 1'b0});
      tag_q.push_back(tag);
   endtask

   // monitor: one result per clock, compared after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(status_o, e, t);
         end
      end
   end

   initial begin
      #(4 * 20000);
      if (!drained) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(status_o, 4'b1000, "R1 reset state");

      step(1, 0, 0, "R8 idle");
      step(0, 0, 32'hFFFF_FFFF, "R2 pad");
      step(0, 0, 32'hFFFF_FFFF, "R2 pad");
      step(0, 0, 32'h0000_00BB, "R2 width detect");
      step(0, 0, 32'h1122_0044, "R2 width detect");
      step(0, 0, NOP, "R2 nop");
      step(0, 0, DESYNC, "R2 command unsynced");
      step(0, 0, RCRC, "R2 command unsynced");
      step(0, 0, CRCC, "R2 command unsynced");
      step(0, 0, 32'h1234_5678, "R2 argument unsynced");
      step(0, 0, SYNC, "R10 sync flag bit 2");

      step(0, 0, 32'hDEAD_BEEF, "R5 data");
      step(0, 0, 32'h0123_4567, "R5 data");
      step(1, 0, DESYNC, "R8 deselected");
      step(1, 1, DESYNC, "R8 deselected read");
      step(1, 0, 0, "R8 idle");
      step(0, 0, CRCC, "R5 compare");
      step(0, 0, m_cks, "R5 good checksum");
      step(0, 0, NOP, "R5 nop synced");

      step(0, 0, DESYNC, "R3 leave session");
      step(0, 0, RCRC, "R3 ignored after");
      step(0, 0, CRCC, "R3 ignored after");
      step(0, 0, 32'h0000_0001, "R3 ignored after");

      step(0, 0, SYNC, "R6 resync");
      step(0, 0, CRCC, "R6 compare");
      step(0, 0, m_cks ^ 32'h1, "R6 bad checksum");
      step(0, 0, RCRC, "R6 unsynced stays");
      step(0, 0, SYNC, "R10 error flag bit 3");
      step(0, 0, RCRC, "R4 release error");
      step(0, 0, CRCC, "R4 compare");
      step(0, 0, 32'h0, "R4 checksum cleared");

      step(0, 0, IDC, "R7 id compare");
      step(0, 0, DEVID, "R7 id match");
      step(0, 0, 32'hCAFE_F00D, "R7 data");
      step(0, 0, CRCC, "R7 compare");
      step(0, 0, m_cks, "R7 id words summed");
      step(0, 0, IDC, "R7 id compare");
      step(0, 0, DEVID ^ 32'h10, "R7 id mismatch");

      step(0, 0, SYNC, "R9 resync");
      step(0, 0, RCRC, "R9 release");
      step(1, 1, 0, "R9 idle");
      step(0, 1, DESYNC, "R9 read cycle");
      step(0, 0, DESYNC, "R9 trigger writes nothing");
      step(0, 0, SYNC, "R9 ignored in abort");
      step(0, 0, SYNC, "R9 ignored in abort");
      step(0, 0, SYNC, "R9 abort end");
      step(1, 0, 0, "R9 after abort");

      step(0, 0, NOP, "R9 write before toggle");
      step(0, 1, 0, "R9 rising toggle");
      step(1, 1, 0, "R9 busy");
      step(1, 1, 0, "R9 busy");
      step(1, 1, 0, "R9 end unsynced");
      step(1, 0, 0, "R9 idle");

      step(0, 0, SYNC, "R10 sync after abort");
      step(0, 0, 32'h5555_AAAA, "R5 data");
      step(0, 0, DESYNC, "R3 leave again");
      step(1, 0, 0, "R3 idle");

      repeat (3) @(posedge clk);
      #1;
      drained = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule